// File: doc/BRIEF.md
# Instruction Field Decoder and Work-Group Classifier

This unit sits between instruction fetch and execute in a five-stage pipeline for a 16-bit register machine. It receives one 16-bit instruction word and splits it into a 4-bit function code, three 4-bit register numbers and an 8-bit immediate. It also sorts the word into one of eleven work groups (0 to 10). The group tells the later stages what to do. Alongside the group it emits control flags: register write to slot C, register write to slot A, a combined write enable, memory read, memory write, PC redirect, stack-pointer update, and a flag saying register C is read as an operand.

Decoding is purely combinational. The result is captured in a single output register with a valid/ready handshake, so the unit can stall when execute is busy. When the function code is zero, the middle register field (B) selects the operation instead of naming a register.

Top module: `ins_dec_top`

## Requirements
- R1: Every captured output carries fn = word[15:12], rc = word[11:8], rb = word[7:4], ra = word[3:0] and imm = word[7:0].
- R2: With fn = 0 and rb equal to 0, 7 or 8, the group is 0 and every control flag is 0.
- R3: With fn = 0 and rb from 9 to 13, the group is 1. The flags wr_c and wr_en are 1 and all other flags are 0.
- R4: With fn from 1 to 11, the group is 2. The flags wr_c and wr_en are 1 and all other flags are 0.
- R5: With fn from 12 to 15, the group is 3. The flags wr_c, wr_en and rd_c are 1 and all other flags are 0.
- R6: With fn = 0 and rb equal to 5 or 6, the group is 4. The flags pc_redir and rd_c are 1 and nothing is written.
- R7: With fn = 0, rb = 1 gives group 5 (mem_rd, wr_c, wr_en). With fn = 0, rb = 2 gives group 6 (mem_wr, rd_c).
- R8: With fn = 0, the stack-related values of rb map as follows:
  - rb = 3 gives group 7 (wr_a, mem_wr, pc_redir, sp_upd, rd_c).
  - rb = 4 gives group 8 (wr_a, mem_rd, pc_redir, sp_upd).
  - rb = 14 gives group 9 (wr_c, wr_a, mem_rd, sp_upd).
  - rb = 15 gives group 10 (wr_a, mem_wr, sp_upd, rd_c).
  - In every case wr_en is 1.
- R9: The flags follow the group as follows:
  - wr_en equals wr_c OR wr_a.
  - mem_rd and mem_wr are never both 1.
  - pc_redir is 1 only for groups 4, 7 and 8.
  - sp_upd is 1 only for groups 7 to 10.
- R10: A word is accepted on a rising edge when in_valid and in_ready are both 1. Its decode appears with out_valid = 1 from that edge on. in_ready is 1 whenever out_valid is 0 or out_ready is 1.
- R11: While out_valid is 1 and out_ready is 0, every output holds its value and out_valid stays 1.
- R12: A synchronous active-high reset clears out_valid on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Unit can take a word this cycle |
| in_word | input | 16 | Instruction word |
| out_valid | output | 1 | Decoded result present |
| out_ready | input | 1 | Downstream takes the result |
| out_fn | output | 4 | Function code |
| out_rc | output | 4 | Register number C |
| out_rb | output | 4 | Register number B / sub-opcode |
| out_ra | output | 4 | Register number A |
| out_imm | output | 8 | Immediate byte |
| out_grp | output | 4 | Work group 0 to 10 |
| out_wr_en | output | 1 | Any register write |
| out_wr_c | output | 1 | Write register C |
| out_wr_a | output | 1 | Write register A |
| out_mem_rd | output | 1 | Memory read |
| out_mem_wr | output | 1 | Memory write |
| out_pc_redir | output | 1 | PC redirect possible |
| out_sp_upd | output | 1 | Stack pointer (register A) updated |
| out_rd_c | output | 1 | Register C used as operand |

## Verification
All decoded fields and flags come out of one register, so each result is due exactly one rising edge after the word is accepted. in_ready is combinational and is due in the same cycle that out_ready changes. The bench drives its inputs and reads the outputs at the falling edge. It keeps a one-entry model of the accepted word and compares every output field against that model at each falling edge. This means a result is checked in the cycle it first appears and again in every stalled cycle after it. Reset is checked one edge after it is raised.

// File: rtl/ins_dec_pkg.sv
package ins_dec_pkg;
    localparam int INSN_W  = 16;
    localparam int NIB_W   = 4;
    localparam int IMM_W   = 8;
    localparam int GRP_W   = 4;
    localparam int NREGF   = INSN_W / NIB_W - 1;

    typedef logic [NIB_W-1:0] nib_t;

    typedef enum logic [GRP_W-1:0] {
        GRP_NOP    = 4'd0,
        GRP_UNARY  = 4'd1,
        GRP_BINARY = 4'd2,
        GRP_TRIPLE = 4'd3,
        GRP_FLOW   = 4'd4,
        GRP_LOAD   = 4'd5,
        GRP_STORE  = 4'd6,
        GRP_CALL   = 4'd7,
        GRP_RET    = 4'd8,
        GRP_POP    = 4'd9,
        GRP_PUSH   = 4'd10
    } grp_e;

    typedef struct packed {
        logic wr_en;
        logic wr_c;
        logic wr_a;
        logic mem_rd;
        logic mem_wr;
        logic pc_redir;
        logic sp_upd;
        logic rd_c;
    } ctrl_t;

    typedef struct packed {
        nib_t             fn;
        nib_t             rc;
        nib_t             rb;
        nib_t             ra;
        logic [IMM_W-1:0] imm;
        grp_e             grp;
        ctrl_t            ctrl;
    } dec_t;

    function automatic ctrl_t grp_ctrl(input grp_e g);
        ctrl_t c;
        c = '0;
        unique case (g)
            GRP_UNARY, GRP_BINARY: c.wr_c = 1'b1;
            GRP_TRIPLE: begin c.wr_c = 1'b1; c.rd_c = 1'b1; end
            GRP_FLOW:   begin c.pc_redir = 1'b1; c.rd_c = 1'b1; end
            GRP_LOAD:   begin c.wr_c = 1'b1; c.mem_rd = 1'b1; end
            GRP_STORE:  begin c.mem_wr = 1'b1; c.rd_c = 1'b1; end
            GRP_CALL:   begin
                c.wr_a = 1'b1; c.mem_wr = 1'b1; c.pc_redir = 1'b1;
                c.sp_upd = 1'b1; c.rd_c = 1'b1;
            end
            GRP_RET:    begin
                c.wr_a = 1'b1; c.mem_rd = 1'b1; c.pc_redir = 1'b1; c.sp_upd = 1'b1;
            end
            GRP_POP:    begin
                c.wr_c = 1'b1; c.wr_a = 1'b1; c.mem_rd = 1'b1; c.sp_upd = 1'b1;
            end
            GRP_PUSH:   begin
                c.wr_a = 1'b1; c.mem_wr = 1'b1; c.sp_upd = 1'b1; c.rd_c = 1'b1;
            end
            default: c = '0;
        endcase
        c.wr_en = c.wr_c | c.wr_a;
        return c;
    endfunction
endpackage

// File: rtl/ins_dec_fields.sv
module ins_dec_fields
    import ins_dec_pkg::*;
(
    input  logic [INSN_W-1:0] word,
    output nib_t              fn,
    output nib_t              rnum [NREGF],
    output logic [IMM_W-1:0]  imm
);
    assign fn  = word[INSN_W-1 -: NIB_W];
    assign imm = word[IMM_W-1:0];

    for (genvar i = 0; i < NREGF; i++) begin : g_rnum
        assign rnum[i] = word[i*NIB_W +: NIB_W];
    end
endmodule

// File: rtl/ins_dec_group.sv
module ins_dec_group
    import ins_dec_pkg::*;
(
    input  nib_t fn,
    input  nib_t sub,
    output grp_e grp
);
    always_comb begin
        grp = GRP_NOP;
        if (fn == '0) begin
            unique case (sub)
                4'd1:  grp = GRP_LOAD;
                4'd2:  grp = GRP_STORE;
                4'd3:  grp = GRP_CALL;
                4'd4:  grp = GRP_RET;
                4'd5, 4'd6: grp = GRP_FLOW;
                4'd9, 4'd10, 4'd11, 4'd12, 4'd13: grp = GRP_UNARY;
                4'd14: grp = GRP_POP;
                4'd15: grp = GRP_PUSH;
                default: grp = GRP_NOP;
            endcase
        end else if (fn >= 4'd12) begin
            grp = GRP_TRIPLE;
        end else begin
            grp = GRP_BINARY;
        end
    end
endmodule

// File: rtl/ins_dec_pipe.sv
module ins_dec_pipe
    import ins_dec_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic in_ready,
    input  dec_t in_dec,
    output logic out_valid,
    input  logic out_ready,
    output dec_t out_dec
);
    logic vld_q;
    dec_t dec_q;

    assign in_ready = !vld_q || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
        end else if (in_ready) begin
            vld_q <= in_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q <= '0;
        end else if (in_valid && in_ready) begin
            dec_q <= in_dec;
        end
    end

    assign out_valid = vld_q;
    assign out_dec   = dec_q;
endmodule

// File: rtl/ins_dec_top.sv
module ins_dec_top
    import ins_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [INSN_W-1:0] in_word,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [NIB_W-1:0]  out_fn,
    output logic [NIB_W-1:0]  out_rc,
    output logic [NIB_W-1:0]  out_rb,
    output logic [NIB_W-1:0]  out_ra,
    output logic [IMM_W-1:0]  out_imm,
    output logic [GRP_W-1:0]  out_grp,
    output logic              out_wr_en,
    output logic              out_wr_c,
    output logic              out_wr_a,
    output logic              out_mem_rd,
    output logic              out_mem_wr,
    output logic              out_pc_redir,
    output logic              out_sp_upd,
    output logic              out_rd_c
);
    nib_t             fn;
    nib_t             rnum [NREGF];
    logic [IMM_W-1:0] imm;
    grp_e             grp;
    dec_t             dec_d;
    dec_t             dec_q;

    ins_dec_fields u_fields (
        .word (in_word),
        .fn   (fn),
        .rnum (rnum),
        .imm  (imm)
    );

    ins_dec_group u_group (
        .fn  (fn),
        .sub (rnum[1]),
        .grp (grp)
    );

    always_comb begin
        dec_d.fn   = fn;
        dec_d.rc   = rnum[2];
        dec_d.rb   = rnum[1];
        dec_d.ra   = rnum[0];
        dec_d.imm  = imm;
        dec_d.grp  = grp;
        dec_d.ctrl = grp_ctrl(grp);
    end

    ins_dec_pipe u_pipe (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_dec    (dec_d),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_dec   (dec_q)
    );

    assign out_fn       = dec_q.fn;
    assign out_rc       = dec_q.rc;
    assign out_rb       = dec_q.rb;
    assign out_ra       = dec_q.ra;
    assign out_imm      = dec_q.imm;
    assign out_grp      = dec_q.grp;
    assign out_wr_en    = dec_q.ctrl.wr_en;
    assign out_wr_c     = dec_q.ctrl.wr_c;
    assign out_wr_a     = dec_q.ctrl.wr_a;
    assign out_mem_rd   = dec_q.ctrl.mem_rd;
    assign out_mem_wr   = dec_q.ctrl.mem_wr;
    assign out_pc_redir = dec_q.ctrl.pc_redir;
    assign out_sp_upd   = dec_q.ctrl.sp_upd;
    assign out_rd_c     = dec_q.ctrl.rd_c;
endmodule

// File: rtl/ins_dec_chk.sv
module ins_dec_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [3:0] out_fn,
    input logic [3:0] out_rb,
    input logic [3:0] out_ra,
    input logic [7:0] out_imm,
    input logic [3:0] out_grp,
    input logic       out_wr_en,
    input logic       out_wr_c,
    input logic       out_wr_a,
    input logic       out_mem_rd,
    input logic       out_mem_wr,
    input logic       out_pc_redir,
    input logic       out_sp_upd
);
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R12
    always_comb begin
        if (rst_q === 1'b1) begin
            reset_clear_chk: assert (!out_valid);
        end
    end

    // R10
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    // R10
    idle_ready_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready);

    // R11
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_fn) && $stable(out_imm)
            && $stable(out_grp) && $stable(out_wr_en) && $stable(out_mem_rd)
            && $stable(out_mem_wr) && $stable(out_pc_redir)));

    // R1
    field_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_imm == {out_rb, out_ra}));

    // R9
    mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $onehot0({out_mem_rd, out_mem_wr}));

    // R9
    wr_en_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_wr_en == (out_wr_c || out_wr_a)));

    // R9
    redir_grp_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_pc_redir) |-> (out_grp == 4'd4 || out_grp == 4'd7 || out_grp == 4'd8));

    // R9
    sp_grp_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sp_upd) |-> (out_grp >= 4'd7 && out_grp <= 4'd10));

    // R4
    binary_grp_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_fn != 4'd0 && out_fn <= 4'd11) |-> (out_grp == 4'd2));
endmodule

bind ins_dec_top ins_dec_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_fn       (out_fn),
    .out_rb       (out_rb),
    .out_ra       (out_ra),
    .out_imm      (out_imm),
    .out_grp      (out_grp),
    .out_wr_en    (out_wr_en),
    .out_wr_c     (out_wr_c),
    .out_wr_a     (out_wr_a),
    .out_mem_rd   (out_mem_rd),
    .out_mem_wr   (out_mem_wr),
    .out_pc_redir (out_pc_redir),
    .out_sp_upd   (out_sp_upd)
);

// File: tb/test_ins_dec_top.sv
module test_ins_dec_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_word = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [3:0]  out_fn, out_rc, out_rb, out_ra, out_grp;
    logic [7:0]  out_imm;
    logic        out_wr_en, out_wr_c, out_wr_a, out_mem_rd, out_mem_wr;
    logic        out_pc_redir, out_sp_upd, out_rd_c;

    int checks = 0;
    int fails  = 0;

    logic        m_valid = 1'b0;
    logic [15:0] m_word  = '0;

    always #4 clk = ~clk;

    ins_dec_top i_ins_dec_top (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
        .out_fn(out_fn), .out_rc(out_rc), .out_rb(out_rb), .out_ra(out_ra),
        .out_imm(out_imm), .out_grp(out_grp), .out_wr_en(out_wr_en),
        .out_wr_c(out_wr_c), .out_wr_a(out_wr_a), .out_mem_rd(out_mem_rd),
        .out_mem_wr(out_mem_wr), .out_pc_redir(out_pc_redir),
        .out_sp_upd(out_sp_upd), .out_rd_c(out_rd_c)
    );

    function automatic logic [3:0] ref_grp(input logic [15:0] w);
        logic [3:0] f, s;
        f = w[15:12];
        s = w[7:4];
        if (f >= 4'd12) return 4'd3;
        if (f != 4'd0)  return 4'd2;
        if (s >= 4'd9 && s <= 4'd13) return 4'd1;
        case (s)
            4'd1: return 4'd5;
            4'd2: return 4'd6;
            4'd3: return 4'd7;
            4'd4: return 4'd8;
            4'd5, 4'd6: return 4'd4;
            4'd14: return 4'd9;
            4'd15: return 4'd10;
            default: return 4'd0;
        endcase
    endfunction

    // flags packed as {wr_en, wr_c, wr_a, mem_rd, mem_wr, pc_redir, sp_upd, rd_c}
    function automatic logic [7:0] ref_flags(input logic [3:0] g);
        case (g)
            4'd1, 4'd2: return 8'b1100_0000;
            4'd3:  return 8'b1100_0001;
            4'd4:  return 8'b0000_0101;
            4'd5:  return 8'b1101_0000;
            4'd6:  return 8'b0000_1001;
            4'd7:  return 8'b1010_1111;
            4'd8:  return 8'b1011_0110;
            4'd9:  return 8'b1111_0010;
            4'd10: return 8'b1010_1011;
            default: return 8'b0000_0000;
        endcase
    endfunction

    function automatic string grp_req(input logic [3:0] g);
        case (g)
            4'd0: return "R2";
            4'd1: return "R3";
            4'd2: return "R4";
            4'd3: return "R5";
            4'd4: return "R6";
            4'd5, 4'd6: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_outputs();
        logic [3:0] g;
        logic [7:0] fl, act_fl;
        check(out_valid == m_valid, "R10", "out_valid", out_valid, m_valid);
        if (m_valid) begin
            g  = ref_grp(m_word);
            fl = ref_flags(g);
            act_fl = {out_wr_en, out_wr_c, out_wr_a, out_mem_rd, out_mem_wr,
                      out_pc_redir, out_sp_upd, out_rd_c};
            check({out_fn, out_rc, out_rb, out_ra} == m_word, "R1", "fields",
                  {out_fn, out_rc, out_rb, out_ra}, m_word);
            check(out_imm == m_word[7:0], "R1", "imm", out_imm, m_word[7:0]);
            check(out_grp == g, grp_req(g), "group", out_grp, g);
            check(act_fl == fl, grp_req(g), "flags", act_fl, fl);
            check(out_wr_en == (out_wr_c | out_wr_a), "R9", "wr_en", out_wr_en,
                  out_wr_c | out_wr_a);
        end
    endtask

    // one cycle: check at falling edge, drive, update model, advance
    task automatic step(input logic v, input logic [15:0] w, input logic rdy);
        check_outputs();
        in_valid  = v;
        in_word   = w;
        out_ready = rdy;
        #1;
        check(in_ready == (!m_valid || rdy), "R10", "in_ready", in_ready, !m_valid || rdy);
        if (v && (!m_valid || rdy)) begin
            m_valid = 1'b1;
            m_word  = w;
        end else if (rdy) begin
            m_valid = 1'b0;
        end
        // R11: when stalled the model keeps m_word, so held outputs are compared
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual running expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R12", "reset valid", out_valid, 0);
        rst = 1'b0;

        // directed sweep of every fn / sub-opcode pair
        for (int f = 0; f < 16; f++) begin
            for (int s = 0; s < 16; s++) begin
                step(1'b1, {f[3:0], 4'hA, s[3:0], 4'h5}, 1'b1);
            end
        end
        step(1'b0, 16'h0, 1'b1);

        // stall: hold a call word with out_ready low (R11)
        step(1'b1, 16'h0434, 1'b1);
        for (int k = 0; k < 4; k++) step(1'b1, 16'h1234, 1'b0);
        step(1'b0, 16'h0, 1'b1);

        // constrained random traffic
        for (int k = 0; k < 3000; k++) begin
            logic [15:0] w;
            w = 16'($urandom);
            if (($urandom % 2) == 0) w[15:12] = 4'h0;
            step(($urandom % 4) != 0, w, ($urandom % 3) != 0);
        end

        // mid-run reset clears valid (R12)
        step(1'b1, 16'h0E12, 1'b0);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R12", "mid reset valid", out_valid, 0);
        rst = 1'b0;
        m_valid = 1'b0;
        step(1'b1, 16'h0F21, 1'b1);
        step(1'b0, 16'h0, 1'b1);
        check_outputs();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule